// File: doc/BRIEF.md
# Chained-Descriptor Memory-to-Peripheral DMA Channel

This block is one DMA channel that streams 16-bit data units from memory into a single peripheral register. Each unit is paced by a request line from the peripheral. The work is described by a chain of four-word descriptors in memory. Each descriptor names the next descriptor, a source address, a destination address and a control word. A chain may close on itself, so that a buffer is replayed without end.

Software writes the address of the first descriptor and pulses start. The channel reads the descriptor one word at a time over a word-wide read port. It then serves one peripheral request per unit, moving the source address forward by two bytes each time and keeping the destination fixed. At the end of each microblock it either follows the chain or stops and raises an interrupt. Per-descriptor flags choose whether the source and the destination address are reloaded when the following descriptor is read.

Top module: `ll_dma_chan`

## Requirements
- R1: After reset the channel is idle: `irq`, `mem_rd` and `per_wr` are low, and requests are not served.
- R2: A start pulse in idle reads the descriptor at byte addresses A, A+4, A+8 and A+12, in that order. Each read is a single-cycle `mem_rd`, and the next read is issued only after the previous `mem_rvalid`. No data read or peripheral write happens before all four words have returned.
- R3: The descriptor fetched from a start pulse loads both the source address (word 1) and the destination address (word 2).
- R4: Each served request reads the 32-bit word at the source address with bits 1:0 cleared. The unit is bits 15:0 of that word when source bit 1 is 0, and bits 31:16 when it is 1. The unit is written with one `per_wr` pulse to the destination address. The source then advances by 2, and the destination does not change within a microblock.
- R5: Control word (word 3) layout: bits 15:0 hold the unit count (at least 1), bit 24 enables chaining, bit 25 is source-reload, bit 26 is destination-reload, and bits 28:27 hold a view code that is ignored. After the count of units, the microblock ends.
- R6: When a microblock ends with chaining set, the descriptor at its word 0 is fetched. The source is reloaded from the new word 1 only if the finished descriptor had source-reload set. The destination is reloaded from the new word 2 only if it had destination-reload set. Otherwise the running value carries on.
- R7: When a microblock ends with chaining clear, `irq` rises on the next cycle and the channel goes idle, serving no further requests.
- R8: `irq` stays high until a `ctl_irq_clr` pulse. If the end-of-chain event and the clear fall in the same cycle, `irq` is set.
- R9: A `ctl_stop` pulse lets the unit in progress finish, and the channel then serves no more requests. A later start fetches afresh and loads both addresses.
- R10: A start pulse while the channel is active is ignored.
- R11: Two descriptors that point at each other, each with 240 units and source-reload set, replay the same 240-unit buffer to the same destination with no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_start | input | 1 | Start pulse, taken only when idle |
| ctl_desc_addr | input | ADDR_W | Byte address of the first descriptor |
| ctl_stop | input | 1 | Stop at the next unit boundary |
| ctl_irq_clr | input | 1 | Clears the interrupt |
| mem_rd | output | 1 | Single-word read strobe |
| mem_addr | output | ADDR_W | Read byte address (word aligned) |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| per_req | input | 1 | Peripheral request, held until `per_wr` |
| per_wr | output | 1 | Peripheral write strobe |
| per_addr | output | ADDR_W | Destination address |
| per_wdata | output | 16 | Data unit |
| irq | output | 1 | End-of-chain interrupt |

## Verification
Two events can land in the same cycle: the interrupt set at the end of a chain and a software clear. The bench's peripheral model raises `ctl_irq_clr` at the very falling edge where it sees the last expected write. That places the clear on the same rising edge that sets the interrupt. `irq` is then required to read high, and to fall only after a separate clear. Random chains with random reload flags, memory latencies and request gaps are checked unit by unit against a descriptor-walking model in the bench.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;
  localparam int MEM_W        = 32;
  localparam int UNIT_W       = 16;
  localparam int UBC_CHAIN    = 24;
  localparam int UBC_SRC_RLD  = 25;
  localparam int UBC_DST_RLD  = 26;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC,
    ST_WAIT,
    ST_DRD,
    ST_DWR
  } seq_st_e;
endpackage

// File: rtl/ll_dma_seq.sv
module ll_dma_seq
  import ll_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              stop_req,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [MEM_W-1:0]  mem_rdata,
  input  logic              per_req,
  output logic              per_wr,
  output logic [ADDR_W-1:0] per_addr,
  output logic [UNIT_W-1:0] per_wdata,
  output logic              eol
);
  localparam logic [ADDR_W-1:0] SRC_STEP = ADDR_W'(2);
  localparam logic [LEN_W-1:0]  LAST_CNT = LEN_W'(1);

  seq_st_e           st_q, st_d;
  logic [1:0]        idx_q, idx_d;
  logic              pend_q, pend_d;
  logic              first_q, first_d;
  logic              stop_q, stop_d;
  logic [ADDR_W-1:0] nda_q, nda_d;
  logic [ADDR_W-1:0] w0_q, w0_d;
  logic [ADDR_W-1:0] w1_q, w1_d;
  logic [ADDR_W-1:0] w2_q, w2_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              chain_q, chain_d;
  logic              srld_q, srld_d;
  logic              drld_q, drld_d;
  logic [UNIT_W-1:0] dat_q, dat_d;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    pend_d  = pend_q;
    first_d = first_q;
    stop_d  = stop_q | stop_req;
    nda_d   = nda_q;
    w0_d    = w0_q;
    w1_d    = w1_q;
    w2_d    = w2_q;
    src_d   = src_q;
    dst_d   = dst_q;
    cnt_d   = cnt_q;
    chain_d = chain_q;
    srld_d  = srld_q;
    drld_d  = drld_q;
    dat_d   = dat_q;
    mem_rd  = 1'b0;
    mem_addr = nda_q + {{(ADDR_W-4){1'b0}}, idx_q, 2'b00};
    per_wr  = 1'b0;
    eol     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        stop_d = 1'b0;
        if (start) begin
          nda_d   = start_addr;
          first_d = 1'b1;
          idx_d   = 2'd0;
          pend_d  = 1'b0;
          st_d    = ST_DESC;
        end
      end
      ST_DESC: begin
        if (!pend_q) begin
          mem_rd = 1'b1;
          pend_d = 1'b1;
        end else if (mem_rvalid) begin
          pend_d = 1'b0;
          idx_d  = idx_q + 2'd1;
          case (idx_q)
            2'd0: w0_d = ADDR_W'(mem_rdata);
            2'd1: w1_d = ADDR_W'(mem_rdata);
            2'd2: w2_d = ADDR_W'(mem_rdata);
            default: begin
              nda_d = w0_q;
              if (first_q || srld_q) src_d = w1_q;
              if (first_q || drld_q) dst_d = w2_q;
              cnt_d   = mem_rdata[LEN_W-1:0];
              chain_d = mem_rdata[UBC_CHAIN];
              srld_d  = mem_rdata[UBC_SRC_RLD];
              drld_d  = mem_rdata[UBC_DST_RLD];
              first_d = 1'b0;
              st_d    = ST_WAIT;
            end
          endcase
        end
      end
      ST_WAIT: begin
        if (stop_q)       st_d = ST_IDLE;
        else if (per_req) st_d = ST_DRD;
      end
      ST_DRD: begin
        mem_addr = {src_q[ADDR_W-1:2], 2'b00};
        if (!pend_q) begin
          mem_rd = 1'b1;
          pend_d = 1'b1;
        end else if (mem_rvalid) begin
          pend_d = 1'b0;
          dat_d  = src_q[1] ? mem_rdata[31:16] : mem_rdata[15:0];
          st_d   = ST_DWR;
        end
      end
      ST_DWR: begin
        per_wr = 1'b1;
        src_d  = src_q + SRC_STEP;
        cnt_d  = cnt_q - LAST_CNT;
        if (cnt_q == LAST_CNT) begin
          if (chain_q) begin
            idx_d = 2'd0;
            st_d  = ST_DESC;
          end else begin
            eol  = 1'b1;
            st_d = ST_IDLE;
          end
        end else begin
          st_d = ST_WAIT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      first_q <= 1'b0;
      stop_q  <= 1'b0;
      nda_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      chain_q <= 1'b0;
      srld_q  <= 1'b0;
      drld_q  <= 1'b0;
      dat_q   <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      pend_q  <= pend_d;
      first_q <= first_d;
      stop_q  <= stop_d;
      nda_q   <= nda_d;
      w0_q    <= w0_d;
      w1_q    <= w1_d;
      w2_q    <= w2_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      cnt_q   <= cnt_d;
      chain_q <= chain_d;
      srld_q  <= srld_d;
      drld_q  <= drld_d;
      dat_q   <= dat_d;
    end
  end

  assign per_addr  = dst_q;
  assign per_wdata = dat_q;

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R2
  AST_WR_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr |-> $past(mem_rvalid)); // R4
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && $past(per_wr)) |-> (src_q == $past(src_q) + SRC_STEP)); // R4
  AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && $past(st_q) == ST_DWR) |-> (dst_q == $past(dst_q))); // R4
  AST_EOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    eol |=> (!mem_rd && !per_wr)); // R7
endmodule

// File: rtl/ll_dma_irq.sv
module ll_dma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_q;
    if (clr_i) irq_d = 1'b0;
    if (set_i) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> irq_o); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_i) |=> irq_o); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !irq_o); // R8
endmodule

// File: rtl/ll_dma_chan.sv
module ll_dma_chan
  import ll_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_start,
  input  logic [ADDR_W-1:0] ctl_desc_addr,
  input  logic              ctl_stop,
  input  logic              ctl_irq_clr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              per_req,
  output logic              per_wr,
  output logic [ADDR_W-1:0] per_addr,
  output logic [15:0]       per_wdata,
  output logic              irq
);
  logic eol;

  ll_dma_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ctl_start),
    .start_addr (ctl_desc_addr),
    .stop_req   (ctl_stop),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .per_req    (per_req),
    .per_wr     (per_wr),
    .per_addr   (per_addr),
    .per_wdata  (per_wdata),
    .eol        (eol)
  );

  ll_dma_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (eol),
    .clr_i (ctl_irq_clr),
    .irq_o (irq)
  );

  AST_IDLE_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !per_wr); // R7
endmodule

// File: tb/sim_ll_dma_chan.sv
`timescale 1ns/1ps
module sim_ll_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_start, ctl_stop, ctl_irq_clr;
  logic [31:0] ctl_desc_addr;
  logic        mem_rd, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        per_req, per_wr;
  logic [31:0] per_addr;
  logic [15:0] per_wdata;
  logic        irq;

  always #4 clk = ~clk;

  ll_dma_chan u0 (
    .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_desc_addr(ctl_desc_addr),
    .ctl_stop(ctl_stop), .ctl_irq_clr(ctl_irq_clr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .per_req(per_req), .per_wr(per_wr),
    .per_addr(per_addr), .per_wdata(per_wdata), .irq(irq)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] exp_a [$];
  logic [15:0] exp_d [$];
  logic [31:0] rd_log [$];
  int    nchk = 0, nfail = 0, nwr = 0, cyc = 0;
  bit    req_en = 0, req_any = 0, clr_now = 0, clr_on_last = 0;
  string wtag = "R4";

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] unit_at(input logic [31:0] a);
    logic [31:0] w = mem[a[11:2]];
    return a[1] ? w[31:16] : w[15:0];
  endfunction

  task automatic put_desc(input logic [31:0] at, input logic [31:0] nda, input logic [31:0] src,
                          input logic [31:0] dst, input int len, input bit ch, input bit sr, input bit dr);
    mem[at[11:2]]     = nda;
    mem[at[11:2] + 1] = src;
    mem[at[11:2] + 2] = dst;
    mem[at[11:2] + 3] = {3'b000, 2'b01, dr, sr, ch, 8'h00, 16'(len)};
  endtask

  // descriptor-walking model of the requirements (R3..R6)
  task automatic model(input logic [31:0] start, input int max_units);
    logic [31:0] nda = start, src = 0, dst = 0, w3;
    bit first = 1, sr = 0, dr = 0;
    int n = 0;
    forever begin
      if (first || sr) src = mem[nda[11:2] + 1];
      if (first || dr) dst = mem[nda[11:2] + 2];
      w3 = mem[nda[11:2] + 3];
      for (int u = 0; u < int'(w3[15:0]); u++) begin
        if (n >= max_units) return;
        exp_a.push_back(dst);
        exp_d.push_back(unit_at(src));
        src += 2;
        n++;
      end
      if (!w3[24]) return;
      sr = w3[25]; dr = w3[26];
      nda = mem[nda[11:2]];
      first = 0;
    end
  endtask

  // memory responder
  bit          mpend = 0;
  int          mlat = 0;
  logic [31:0] maddr;
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (mpend) begin
      if (mlat == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[maddr[11:2]];
        mpend      = 0;
      end else mlat--;
    end else if (rst_n && mem_rd) begin
      mpend = 1;
      maddr = mem_addr;
      mlat  = $urandom_range(0, 2);
      rd_log.push_back(mem_addr);
    end
  end

  // peripheral model and interrupt clear driver
  always @(negedge clk) begin
    logic [31:0] ea;
    logic [15:0] ed;
    if (!rst_n) begin
      per_req = 1'b0;
      ctl_irq_clr = 1'b0;
    end else begin
      ctl_irq_clr = 1'b0;
      if (clr_now) begin ctl_irq_clr = 1'b1; clr_now = 0; end
      if (per_wr) begin
        per_req = 1'b0;
        nwr++;
        if (exp_a.size() == 0) chk(0, {wtag, " unexpected write"}, {per_addr, per_wdata}, 0);
        else begin
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          chk(per_addr == ea && per_wdata == ed, wtag, {per_addr, per_wdata}, {ea, ed});
          if (exp_a.size() == 0 && clr_on_last) begin ctl_irq_clr = 1'b1; clr_on_last = 0; end
        end
      end else if (req_en && !per_req && (exp_a.size() > 0 || req_any) && ($urandom % 3 == 0))
        per_req = 1'b1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic start_at(input logic [31:0] a);
    ctl_desc_addr = a; ctl_start = 1'b1;
    tick(1);
    ctl_start = 1'b0;
  endtask

  task automatic stop_pulse();
    ctl_stop = 1'b1;
    tick(1);
    ctl_stop = 1'b0;
  endtask

  task automatic drain(input string tag);
    int c = 0;
    while (exp_a.size() != 0 && c < 20000) begin tick(1); c++; end
    chk(exp_a.size() == 0, {tag, " drain"}, exp_a.size(), 0);
    tick(4);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    rst_n = 1'b0; ctl_start = 0; ctl_stop = 0; ctl_desc_addr = 0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(mem_rd == 1'b0, "R1 mem_rd", mem_rd, 0);
    chk(per_wr == 1'b0, "R1 per_wr", per_wr, 0);

    // S1: single descriptor, odd halfword start
    put_desc(32'h100, 32'h0, 32'h402, 32'h8000_0010, 5, 0, 0, 0);
    rd_log.delete();
    model(32'h100, 1000);
    wtag = "R3 first-load write";
    req_en = 1;
    start_at(32'h100);
    drain("R3");
    for (int k = 0; k < 4; k++)
      chk(rd_log[k] == 32'h100 + 32'(4 * k), "R2 descriptor read order", rd_log[k], 32'h100 + 32'(4 * k));
    chk(rd_log[4] == 32'h400, "R2 data read after descriptor", rd_log[4], 32'h400);
    chk(irq == 1'b1, "R7 irq at chain end", irq, 1);
    wtag = "R7 idle after end";
    req_any = 1;
    tick(30);
    req_any = 0;
    chk(irq == 1'b1, "R8 irq held", irq, 1);
    clr_now = 1;
    tick(3);
    chk(irq == 1'b0, "R8 irq cleared", irq, 0);

    // S2: three-descriptor chain with mixed reload flags, clear on the set cycle
    put_desc(32'h140, 32'h160, 32'h500, 32'h9000_0000, 3, 1, 1, 0);
    put_desc(32'h160, 32'h180, 32'h600, 32'h9000_0100, 4, 1, 0, 1);
    put_desc(32'h180, 32'h0,   32'h700, 32'h9000_0200, 2, 0, 0, 0);
    model(32'h140, 1000);
    wtag = "R6 reload flags";
    clr_on_last = 1;
    start_at(32'h140);
    drain("R6");
    chk(irq == 1'b1, "R8 set wins over clear", irq, 1);
    clr_now = 1;
    tick(3);
    chk(irq == 1'b0, "R8 clear after set", irq, 0);

    // S3: two-descriptor loop of 240 units each; start while busy is ignored
    put_desc(32'h200, 32'h210, 32'h800, 32'hA000_0000, 240, 1, 1, 0);
    put_desc(32'h210, 32'h200, 32'h800, 32'hA000_0004, 240, 1, 1, 0);
    model(32'h200, 500);
    wtag = "R11 loop replay";
    start_at(32'h200);
    while (nwr < 180) tick(1);
    wtag = "R10 start ignored while busy";
    start_at(32'h100);
    drain("R11");
    chk(irq == 1'b0, "R11 no irq in loop", irq, 0);
    stop_pulse();
    tick(5);
    wtag = "R9 write after stop";
    req_any = 1;
    tick(60);
    req_any = 0;
    tick(5);
    chk(irq == 1'b0, "R9 no irq on stop", irq, 0);
    model(32'h200, 10);
    wtag = "R9 restart reloads both";
    start_at(32'h200);
    drain("R9");
    stop_pulse();
    tick(20);

    // S4: random chains (R5, R6)
    for (int it = 0; it < 6; it++) begin
      int nd = $urandom_range(1, 3);
      logic [31:0] base = 32'h300 + 32'(it % 4) * 32'h40;
      for (int d = 0; d < nd; d++) begin
        logic [31:0] at = base + 32'(d) * 16;
        put_desc(at, at + 16, 32'h800 + 32'($urandom % 32'h300) * 2,
                 {$urandom, 1'b0} & 32'hFFFF_FFFE, $urandom_range(1, 8),
                 d != nd - 1, 1'($urandom), 1'($urandom));
      end
      model(base, 1000);
      wtag = "R5 random chain";
      start_at(base);
      drain("R5");
      chk(irq == 1'b1, "R7 random end irq", irq, 1);
      clr_now = 1;
      tick(3);
      chk(irq == 1'b0, "R8 random clear", irq, 0);
    end
    summary();
  end
endmodule